// File: doc/BRIEF.md
# Dual-Compare General-Purpose Timer

This block is a 16-bit up-counter that advances once per qualified timer event and drives one timer output pin. It has two limit registers, A and B. In single-limit operation only A is used. When the counter would reach A, it wraps to zero in the same clock edge. The output then goes low for one clock. In alternating operation the counter uses A and B in turn as its limit on successive periods. The output is high while counting toward A and low while counting toward B, so the two values set both the frequency and the duty cycle of a square wave.

Timer events come from one of three sources: the system clock divided down as a clock-enable, a synchronized external input whose rising edges count, or a tick from a neighbouring prescaler. The control register selects the source. It also selects continuous or one-shot operation; in one-shot operation the timer disables itself after the first wrap. A sticky terminal-count flag records every wrap. A small write/read register port gives software access to the count, both limits and the control word at any time.

Top module: `dualcmp_timer`

## Requirements
- R1: After reset the count, both limits and the control word read 0, `tmr_out` is 1 and `tc_flag` is 0. Register addresses are 0 count, 1 limit A, 2 limit B, 3 control. Control bits: [0] enable, [1] alternate, [2] continuous, [4:3] source (0 divided clock, 1 external pin, 2 prescale input, 3 none), [5] terminal-count flag.
- R2: While enabled, the count rises by exactly one per timer event and holds its value between events.
- R3: On the event that would make the count equal the active limit, the count becomes 0 instead. The count never reads as the limit it is running toward. A wrap sets the flag.
- R4: All four registers can be written and read back at any time. A count write while running takes effect at once and wins over an event in the same cycle.
- R5: With alternate clear and continuous set, the period is A events. `tmr_out` is low for exactly one clock after each wrap and high otherwise.
- R6: With alternate and continuous set, `tmr_out` is high for A events and low for B events, in turn. Enabling from the disabled state always restarts in the A (high) phase.
- R7: With continuous clear, the enable bit reads 0 after the first wrap and the count stays at 0 under further events.
- R8: The flag (control bit 5, mirrored on `tc_flag`) stays set until control is written with bit 5 = 1. Writing 0 in bit 5 leaves it set.
- R9: Source 0 gives one event every 4 clocks (DIV = 4). Source 1 gives one event per rising edge of `ext_pin`, however long the pin stays high. Source 2 gives one event per clock in which `pre_tick` is 1.
- R10: While disabled, `tmr_out` is 1, apart from the single low clock that may follow the last wrap in single-limit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ext_pin | input | 1 | External event input (asynchronous) |
| pre_tick | input | 1 | Prescale tick from a neighbour timer |
| tmr_out | output | 1 | Timer output waveform |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The bench builds the block with its default values: a 16-bit count, a divide-by-4 internal source and a two-stage synchronizer. Holding `pre_tick` high gives one event per clock. With this setting the bench sweeps every limit pair from 1 to 4 in alternating mode and limits 2 to 7 in single-limit mode, and measures each high and low run in clocks. Single pulses on the prescale and external inputs give exact event counts. These reach the wrap boundary, the one-shot stop, the flag clearing and the phase restart.

// File: rtl/dualcmp_timer_pkg.sv
package dualcmp_timer_pkg;

  localparam logic [1:0] SRC_DIV  = 2'd0;
  localparam logic [1:0] SRC_EXT  = 2'd1;
  localparam logic [1:0] SRC_PRE  = 2'd2;

  localparam int unsigned ADDR_CNT  = 0;
  localparam int unsigned ADDR_LIMA = 1;
  localparam int unsigned ADDR_LIMB = 2;
  localparam int unsigned ADDR_CTRL = 3;

  localparam int unsigned CTRL_W = 6;

  typedef struct packed {
    logic       flag;
    logic [1:0] src;
    logic       cont;
    logic       alt;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/dualcmp_rst_sync.sv
module dualcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dualcmp_tick_gen.sv
module dualcmp_tick_gen
  import dualcmp_timer_pkg::*;
#(
  parameter int unsigned DIV        = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] src,
  input  logic       ext_pin,
  input  logic       pre_tick,
  output logic       tick
);

  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic tick_div;
  logic tick_ext;

  generate
    if (DIV > 1) begin : g_div
      logic [DW-1:0] div_q, div_d;
      logic          div_last;

      assign div_last = (div_q == DW'(DIV - 1));

      always_comb begin
        if (!en)           div_d = '0;
        else if (div_last) div_d = '0;
        else               div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick_div = en && div_last;

      // R9: divided source never produces two events in a row
      a_r9_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_DIV && tick) |=> !tick);
    end else begin : g_nodiv
      assign tick_div = en;
    end
  endgenerate

  logic [SYNC_DEPTH-1:0] sync_q, sync_d;
  logic                  ext_last_q;

  always_comb begin
    sync_d = {sync_q[SYNC_DEPTH-2:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ext_last_q <= 1'b0;
    end else begin
      sync_q     <= sync_d;
      ext_last_q <= sync_q[SYNC_DEPTH-1];
    end
  end

  assign tick_ext = sync_q[SYNC_DEPTH-1] && !ext_last_q;

  always_comb begin
    case (src)
      SRC_DIV: tick = tick_div;
      SRC_EXT: tick = tick_ext;
      SRC_PRE: tick = pre_tick;
      default: tick = 1'b0;
    endcase
  end

  // R9: an external level produces a single event per rising edge
  a_r9_ext_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT && tick) |=> !tick);

endmodule

// File: rtl/dualcmp_core.sv
module dualcmp_core
  import dualcmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output ctrl_t            ctrl,
  output logic             tmr_out
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lima_q, lima_d;
  logic [CNT_W-1:0] limb_q, limb_d;
  ctrl_t            ctl_q, ctl_d;
  logic             phase_q, phase_d;
  logic             out_q, out_d;

  logic             wr_cnt, wr_lima, wr_limb, wr_ctl;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             adv;
  logic             roll;
  logic             start;

  assign wr_cnt  = bus_wr && (bus_addr == 2'(ADDR_CNT));
  assign wr_lima = bus_wr && (bus_addr == 2'(ADDR_LIMA));
  assign wr_limb = bus_wr && (bus_addr == 2'(ADDR_LIMB));
  assign wr_ctl  = bus_wr && (bus_addr == 2'(ADDR_CTRL));

  assign limit   = (ctl_q.alt && phase_q) ? limb_q : lima_q;
  assign cnt_inc = cnt_q + 1'b1;
  assign adv     = ctl_q.en && tick;
  assign roll    = adv && (cnt_inc == limit) && !wr_cnt;
  assign start   = wr_ctl && bus_wdata[0] && !ctl_q.en;

  always_comb begin
    if (wr_cnt)     cnt_d = bus_wdata;
    else if (roll)  cnt_d = '0;
    else if (adv)   cnt_d = cnt_inc;
    else            cnt_d = cnt_q;

    lima_d = wr_lima ? bus_wdata : lima_q;
    limb_d = wr_limb ? bus_wdata : limb_q;

    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.en   = bus_wdata[0];
      ctl_d.alt  = bus_wdata[1];
      ctl_d.cont = bus_wdata[2];
      ctl_d.src  = bus_wdata[4:3];
    end else if (roll && !ctl_q.cont) begin
      ctl_d.en = 1'b0;
    end
    if (roll)                         ctl_d.flag = 1'b1;
    else if (wr_ctl && bus_wdata[5])  ctl_d.flag = 1'b0;

    if (start)                  phase_d = 1'b0;
    else if (roll && ctl_q.alt) phase_d = !phase_q;
    else                        phase_d = phase_q;

    if (ctl_q.alt) out_d = ctl_d.en ? !phase_d : 1'b1;
    else           out_d = !roll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lima_q  <= '0;
      limb_q  <= '0;
      ctl_q   <= '0;
      phase_q <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      lima_q  <= lima_d;
      limb_q  <= limb_d;
      ctl_q   <= ctl_d;
      phase_q <= phase_d;
      out_q   <= out_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'(ADDR_CNT):  bus_rdata = cnt_q;
      2'(ADDR_LIMA): bus_rdata = lima_q;
      2'(ADDR_LIMB): bus_rdata = limb_q;
      default:       bus_rdata[CTRL_W-1:0] = ctl_q;
    endcase
  end

  assign ctrl    = ctl_q;
  assign tmr_out = out_q;

  // R2: no event and no write leaves the count unchanged
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_q.en && tick) && !wr_cnt) |=> $stable(cnt_q));

  // R3: reaching the limit lands on zero and raises the flag
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && tick && !wr_cnt && (cnt_q + 1'b1 == limit)) |=> (cnt_q == '0 && ctl_q.flag));

  // R5: a low output in single-limit mode always follows an event
  a_r5_low_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.alt && !$past(ctl_q.alt) && !out_q) |-> $past(ctl_q.en && tick));

  // R6: enabling restarts in the A phase
  a_r6_phase_a_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.en) |-> !phase_q);

  // R7: one-shot disables itself after its wrap
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !ctl_q.cont && !wr_ctl) |=> !ctl_q.en);

  // R8: flag is cleared only by writing 1 to it
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !(wr_ctl && bus_wdata[5])) |=> ctl_q.flag);

  // R10: in alternate mode a disabled timer keeps the output high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.alt && !wr_ctl && !ctl_q.en) |=> (out_q || ctl_q.en));

endmodule

// File: rtl/dualcmp_timer.sv
module dualcmp_timer
  import dualcmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DIV        = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_pin,
  input  logic             pre_tick,
  output logic             tmr_out,
  output logic             tc_flag
);

  logic  rst_n_int;
  logic  tick;
  ctrl_t ctrl;

  dualcmp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dualcmp_tick_gen #(.DIV(DIV), .SYNC_DEPTH(SYNC_DEPTH)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .en       (ctrl.en),
    .src      (ctrl.src),
    .ext_pin  (ext_pin),
    .pre_tick (pre_tick),
    .tick     (tick)
  );

  dualcmp_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .tmr_out   (tmr_out)
  );

  assign tc_flag = ctrl.flag;

endmodule

// File: tb/dualcmp_timer_tb_top.sv
`timescale 1ns/1ps
module dualcmp_timer_tb_top;

  localparam int W = 16;
  localparam logic [W-1:0] C_EN = 16'd1, C_ALT = 16'd2, C_CONT = 16'd4,
                           C_EXT = 16'd8, C_PRE = 16'd16, C_FLAG = 16'd32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         ext_pin;
  logic         pre_tick;
  logic         tmr_out;
  logic         tc_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  dualcmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .pre_tick(pre_tick), .tmr_out(tmr_out), .tc_flag(tc_flag)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[1:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = a[1:0];
    #0.5;
    v = int'(bus_rdata);
  endtask

  task automatic pulse_pre();
    @(negedge clk); pre_tick = 1'b1;
    @(negedge clk); pre_tick = 1'b0;
  endtask

  // run length of the current output level, sampled at negedges
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tmr_out === lvl && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_level(input logic lvl);
    int g = 0;
    while (tmr_out !== lvl && g < 200) begin
      g++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, hi, lo;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_pin = 1'b0; pre_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v); check($sformatf("R1 reg%0d", a), v, 0);
    end
    check("R1 tmr_out", tmr_out, 1);
    check("R1 tc_flag", tc_flag, 0);

    // R3 / R2 wrap boundary with single prescale events, limit A=5
    wr(1, 16'd5); wr(0, 16'd0); wr(3, C_EN | C_CONT | C_PRE);
    for (int i = 1; i <= 5; i++) begin
      pulse_pre();
      rd(0, v); check($sformatf("R3 count after %0d events", i), v, i % 5);
    end
    check("R3 flag after wrap", tc_flag, 1);
    repeat (10) @(negedge clk);
    rd(0, v); check("R2 hold without events", v, 0);
    pulse_pre(); pulse_pre();
    rd(0, v); check("R2 two events", v, 2);

    // R8 flag sticky, write-1-to-clear
    wr(3, C_EN | C_CONT | C_PRE);
    rd(3, v); check("R8 flag kept by writing 0", (v >> 5) & 1, 1);
    check("R8 tc_flag port kept", tc_flag, 1);
    wr(3, C_EN | C_CONT | C_PRE | C_FLAG);
    rd(3, v); check("R8 flag cleared by writing 1", (v >> 5) & 1, 0);
    check("R8 tc_flag port cleared", tc_flag, 0);

    // R7 one-shot, A=3
    wr(3, C_FLAG); wr(1, 16'd3); wr(0, 16'd0); wr(3, C_EN | C_PRE);
    repeat (3) pulse_pre();
    rd(0, v); check("R7 count after one-shot wrap", v, 0);
    rd(3, v); check("R7 enable cleared", v & 1, 0);
    repeat (2) pulse_pre();
    rd(0, v); check("R7 count stays after stop", v, 0);
    repeat (2) @(negedge clk);
    check("R10 output high while disabled", tmr_out, 1);

    // R4 count write while running wins over a tick
    wr(1, 16'd1000); wr(0, 16'd0);
    @(negedge clk); pre_tick = 1'b1;
    wr(3, C_EN | C_CONT | C_PRE);
    repeat (5) @(negedge clk);
    wr(0, 16'd50);
    rd(0, v); check("R4 count write while running", v, 50);
    @(negedge clk);
    rd(0, v); check("R4 count resumes after write", v, 51);
    rd(1, v); check("R4 limit A readback", v, 1000);
    pre_tick = 1'b0;
    wr(3, C_FLAG);

    // R5 single-limit sweep, one event per clock
    pre_tick = 1'b1;
    for (int a = 2; a <= 7; a++) begin
      wr(1, a[W-1:0]); wr(0, 16'd0); wr(3, C_EN | C_CONT | C_PRE);
      wait_level(1'b0); wait_level(1'b1); wait_level(1'b0);
      run_len(1'b0, lo); run_len(1'b1, hi);
      check($sformatf("R5 A=%0d low clocks", a), lo, 1);
      check($sformatf("R5 A=%0d high clocks", a), hi, a - 1);
      wr(3, C_FLAG);
    end

    // R6 alternate sweep over all pairs 1..4
    wr(2, 16'd0);
    for (int a = 1; a <= 4; a++) begin
      for (int b = 1; b <= 4; b++) begin
        wr(1, a[W-1:0]); wr(2, b[W-1:0]); wr(0, 16'd0);
        wr(3, C_EN | C_ALT | C_CONT | C_PRE);
        wait_level(1'b0); wait_level(1'b1);
        run_len(1'b1, hi); run_len(1'b0, lo);
        check($sformatf("R6 A=%0d B=%0d high clocks", a, b), hi, a);
        check($sformatf("R6 A=%0d B=%0d low clocks", a, b), lo, b);
        wr(3, C_FLAG);
      end
    end

    // R6 restart in A phase after disabling during the B phase
    wr(1, 16'd6); wr(2, 16'd6); wr(0, 16'd0);
    wr(3, C_EN | C_ALT | C_CONT | C_PRE);
    wait_level(1'b0);
    repeat (2) @(negedge clk);
    wr(3, C_ALT | C_CONT | C_PRE | C_FLAG);
    @(negedge clk);
    check("R10 alt output high while disabled", tmr_out, 1);
    wr(0, 16'd0); wr(3, C_EN | C_ALT | C_CONT | C_PRE);
    run_len(1'b1, hi);
    check("R6 restart high for A", hi, 6);
    pre_tick = 1'b0;
    wr(3, C_FLAG);

    // R9 divided source, single-limit A=3: period 12 clocks
    wr(1, 16'd3); wr(0, 16'd0); wr(3, C_EN | C_CONT);
    wait_level(1'b0); wait_level(1'b1); wait_level(1'b0);
    run_len(1'b0, lo); run_len(1'b1, hi);
    check("R9 divided source low clocks", lo, 1);
    check("R9 divided source high clocks", hi, 11);
    wr(3, C_FLAG);

    // R9 external pin edges
    wr(1, 16'd1000); wr(0, 16'd0); wr(3, C_EN | C_CONT | C_EXT);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (3) @(negedge clk); ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(0, v); check("R9 five external edges", v, 5);
    ext_pin = 1'b1;
    repeat (10) @(negedge clk); ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(0, v); check("R9 long external high counts once", v, 6);
    wr(3, C_FLAG);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule